// File: doc/BRIEF.md
# Flash Erase Command Register Unit

This unit is a small bank of memory-mapped control registers that stands between software and an on-chip flash array. Erase operations are guarded twice. First, a target must be armed by a separate register write. Second, a specific key byte must be written to the command register. Each arming write covers exactly one accepted erase. After that it must be written again.

Page erase needs a fresh page-number write. Full-array (mass) erase needs the mass-arm bit to be set. It also needs the debug port to be enabled. The unit also holds a program-enable bit and a security flag. The program-enable bit drops after every byte written to flash. The security flag, once set, holds until reset.

The flash array is modelled by a simple handshake. The unit raises a one-cycle request carrying the page number. It treats the flash as busy from that request until the flash returns `erase_done`.

Top module: `flash_erase_ctl`

## Requirements
- R1: Writing 0x55 to the command register (address 0) raises `page_erase_req` for exactly one cycle, on the clock after the write. This happens only when the page register was written since the last accepted page erase. `erase_page` then carries the page number captured at acceptance.
- R2: Writing 0xAA to the command register raises `mass_erase_req` for one cycle, on the clock after the write. This happens only when the mass-arm bit is 1 and `dbg_en` is high in the write cycle.
- R3: Writing any value other than 0x55 or 0xAA to the command register changes no output and no register.
- R4: The page register (address 1) holds a PAGE_W-bit page number in data bits [PAGE_W-1:0]. It resets to 0 and reads back in those bits with the upper bits 0. Every write to it arms page erase.
- R5: The mass-arm bit (address 2, bit 0) resets to 0. A write loads it from bit 0 of the data. It reads back in bit 0.
- R6: The program-enable bit (address 3, bit 0) resets to 0 and drives `prog_en`. A write loads it from data bit 0 only while `irq_en` is low. A `flash_byte_wr` pulse clears it on the next clock, and this clearing wins over a write in the same cycle.
- R7: The security bit (address 4, bit 0) resets to 0 and drives `secure`. Writing a 1 sets it. Writing a 0 is ignored. Only reset clears it.
- R8: The flash counts as busy from an accepted erase until the clock that samples `erase_done` high. Any erase command written while it is busy is ignored, and both arming flags are kept.
- R9: Accepting a page erase clears the page-arm flag. Accepting a mass erase clears the mass-arm bit.
- R10: Reading the command register, or any address above 4, returns 0x00. `reg_rdata` is combinational from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| dbg_en | input | 1 | Debug port enabled; required for mass erase |
| irq_en | input | 1 | Interrupts enabled; blocks program-enable writes |
| flash_byte_wr | input | 1 | Strobe: one byte was written to flash |
| erase_done | input | 1 | Flash reports that the current erase has finished |
| page_erase_req | output | 1 | One-cycle page erase request |
| mass_erase_req | output | 1 | One-cycle mass erase request |
| erase_page | output | PAGE_W | Page number of the last accepted page erase |
| prog_en | output | 1 | Program-enable level |
| secure | output | 1 | Sticky security flag |

## Verification
The bench builds the unit with its defaults, ADDR_W=3 and PAGE_W=7. With a 3-bit address, the random stimulus reaches every mapped register as well as the three unmapped addresses. With a 7-bit page field, random write data covers the full page range 0 to 127, including the ignored top data bit.

The key bytes are drawn with high weight, so accepted, unarmed, busy-blocked and debug-blocked commands all occur many times. The bench answers each request with a randomly delayed `erase_done`, so commands land both inside and outside the busy window.

// File: rtl/fe_pkg.sv
package fe_pkg;
    localparam int DATA_W   = 8;
    localparam int NUM_REGS = 5;

    typedef enum int {
        REG_CMD  = 0,
        REG_PAGE = 1,
        REG_MARM = 2,
        REG_PROG = 3,
        REG_SEC  = 4
    } reg_idx_e;

    localparam logic [DATA_W-1:0] KEY_PAGE = 8'h55;
    localparam logic [DATA_W-1:0] KEY_MASS = 8'hAA;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_PAGE = 2'd1,
        CMD_MASS = 2'd2
    } cmd_kind_e;
endpackage

// File: rtl/fe_reg_decode.sv
module fe_reg_decode #(
    parameter int ADDR_W = 3,
    parameter int NREG   = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   hit
);
    for (genvar i = 0; i < NREG; i++) begin : g_hit
        assign hit[i] = (addr == ADDR_W'(i));
    end
endmodule

// File: rtl/fe_cmd_classify.sv
module fe_cmd_classify
    import fe_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output cmd_kind_e         kind
);
    always_comb begin
        if (data == KEY_PAGE)      kind = CMD_PAGE;
        else if (data == KEY_MASS) kind = CMD_MASS;
        else                       kind = CMD_NONE;
    end
endmodule

// File: rtl/flash_erase_ctl.sv
module flash_erase_ctl
    import fe_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dbg_en,
    input  logic              irq_en,
    input  logic              flash_byte_wr,
    input  logic              erase_done,
    output logic              page_erase_req,
    output logic              mass_erase_req,
    output logic [PAGE_W-1:0] erase_page,
    output logic              prog_en,
    output logic              secure
);
    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic              page_arm;
        logic              mass_arm;
        logic              prog;
        logic              sec;
        logic              busy;
        logic              preq;
        logic              mreq;
        logic [PAGE_W-1:0] epage;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_REGS-1:0] hit;
    logic [NUM_REGS-1:0] wsel;
    cmd_kind_e           kind;
    logic                cmd_open;
    logic                take_page;
    logic                take_mass;
    logic                busy_q;

    fe_reg_decode #(.ADDR_W(ADDR_W), .NREG(NUM_REGS)) u_dec (
        .addr (reg_addr),
        .hit  (hit)
    );

    fe_cmd_classify u_cls (
        .data (reg_wdata),
        .kind (kind)
    );

    assign wsel      = hit & {NUM_REGS{reg_wr}};
    assign cmd_open  = wsel[REG_CMD] && !state_q.busy;
    assign take_page = cmd_open && (kind == CMD_PAGE) && state_q.page_arm;
    assign take_mass = cmd_open && (kind == CMD_MASS) && state_q.mass_arm && dbg_en;

    always_comb begin
        state_d      = state_q;
        state_d.preq = take_page;
        state_d.mreq = take_mass;

        if (wsel[REG_PAGE]) begin
            state_d.page     = reg_wdata[PAGE_W-1:0];
            state_d.page_arm = 1'b1;
        end
        if (take_page) begin
            state_d.page_arm = 1'b0;
            state_d.epage    = state_q.page;
        end

        if (wsel[REG_MARM]) state_d.mass_arm = reg_wdata[0];
        if (take_mass)      state_d.mass_arm = 1'b0;

        if (flash_byte_wr)                 state_d.prog = 1'b0;
        else if (wsel[REG_PROG] && !irq_en) state_d.prog = reg_wdata[0];

        if (wsel[REG_SEC] && reg_wdata[0]) state_d.sec = 1'b1;

        if (take_page || take_mass) state_d.busy = 1'b1;
        else if (erase_done)        state_d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (hit[REG_PAGE])      reg_rdata = DATA_W'(state_q.page);
        else if (hit[REG_MARM]) reg_rdata = DATA_W'(state_q.mass_arm);
        else if (hit[REG_PROG]) reg_rdata = DATA_W'(state_q.prog);
        else if (hit[REG_SEC])  reg_rdata = DATA_W'(state_q.sec);
    end

    assign busy_q         = state_q.busy;
    assign page_erase_req = state_q.preq;
    assign mass_erase_req = state_q.mreq;
    assign erase_page     = state_q.epage;
    assign prog_en        = state_q.prog;
    assign secure         = state_q.sec;
endmodule

// File: rtl/fe_chk.sv
module fe_chk
    import fe_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              dbg_en,
    input logic              flash_byte_wr,
    input logic              page_erase_req,
    input logic              mass_erase_req,
    input logic              prog_en,
    input logic              secure,
    input logic              busy
);
    // R1
    page_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_erase_req |-> $past(reg_wr && reg_addr == '0 && reg_wdata == KEY_PAGE));
    // R2
    mass_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mass_erase_req |-> $past(reg_wr && reg_addr == '0 && reg_wdata == KEY_MASS && dbg_en));
    // R8
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (page_erase_req || mass_erase_req) |-> !$past(busy));
    // R6
    prog_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flash_byte_wr) |-> !prog_en);
    // R7
    secure_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(secure));
    // R1
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(page_erase_req && mass_erase_req));
endmodule

bind flash_erase_ctl fe_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_wr         (reg_wr),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .dbg_en         (dbg_en),
    .flash_byte_wr  (flash_byte_wr),
    .page_erase_req (page_erase_req),
    .mass_erase_req (mass_erase_req),
    .prog_en        (prog_en),
    .secure         (secure),
    .busy           (busy_q)
);

// File: tb/tb_flash_erase_ctl.sv
module tb_flash_erase_ctl;
    localparam int ADDR_W = 3;
    localparam int PAGE_W = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [7:0]        reg_wdata = '0;
    logic [7:0]        reg_rdata;
    logic              dbg_en = 1'b0;
    logic              irq_en = 1'b0;
    logic              flash_byte_wr = 1'b0;
    logic              erase_done = 1'b0;
    logic              page_erase_req, mass_erase_req, prog_en, secure;
    logic [PAGE_W-1:0] erase_page;

    int checks = 0;
    int fails  = 0;

    // bench-side expected state
    logic [PAGE_W-1:0] m_page = '0, m_epage = '0;
    logic m_parm = 0, m_marm = 0, m_prog = 0, m_sec = 0, m_busy = 0, m_preq = 0, m_mreq = 0;

    always #5 clk = ~clk;

    flash_erase_ctl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) dut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [ADDR_W-1:0] a);
        case (a)
            3'd1:    return 8'(m_page);
            3'd2:    return 8'(m_marm);
            3'd3:    return 8'(m_prog);
            3'd4:    return 8'(m_sec);
            default: return 8'h00;
        endcase
    endfunction

    function automatic string rd_tag(input logic [ADDR_W-1:0] a);
        case (a)
            3'd1:    return "R4";
            3'd2:    return "R5";
            3'd3:    return "R6";
            3'd4:    return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic check_outputs();
        chk("R1 R8 R9 page_erase_req", page_erase_req, m_preq);
        chk("R2 R8 R9 mass_erase_req", mass_erase_req, m_mreq);
        chk("R1 erase_page", erase_page, m_epage);
        chk("R6 prog_en", prog_en, m_prog);
        chk("R7 secure", secure, m_sec);
    endtask

    task automatic step(input logic wr, input logic [ADDR_W-1:0] a, input logic [7:0] d,
                        input logic dbg, input logic irq, input logic bw, input logic done);
        logic cmd_ok, p, m;
        @(negedge clk);
        check_outputs();
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        dbg_en = dbg; irq_en = irq; flash_byte_wr = bw; erase_done = done;
        #1;
        chk(rd_tag(a), reg_rdata, exp_rd(a));
        @(posedge clk);
        cmd_ok = wr && a == 0 && !m_busy;
        p = cmd_ok && d == 8'h55 && m_parm;
        m = cmd_ok && d == 8'hAA && m_marm && dbg;
        if (p) m_epage = m_page;
        if (wr && a == 1) begin m_page = d[PAGE_W-1:0]; m_parm = 1; end
        if (p) m_parm = 0;
        if (wr && a == 2) m_marm = d[0];
        if (m) m_marm = 0;
        if (bw) m_prog = 0;
        else if (wr && a == 3 && !irq) m_prog = d[0];
        if (wr && a == 4 && d[0]) m_sec = 1;
        if (p || m) m_busy = 1;
        else if (done) m_busy = 0;
        m_preq = p; m_mreq = m;
    endtask

    initial begin
        void'($urandom(32'h1F2E_3D4C));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state
        check_outputs();
        rst_n = 1'b1;
        // R1: unarmed page erase after reset is ignored
        step(1, 0, 8'h55, 1, 0, 0, 0);
        // R4 R1: arm and erase page 127
        step(1, 1, 8'hFF, 1, 0, 0, 0);
        step(1, 0, 8'h55, 1, 0, 0, 0);
        // R8: second command while busy ignored
        step(1, 1, 8'h05, 1, 0, 0, 0);
        step(1, 0, 8'h55, 1, 0, 0, 1);
        // R9 R1: page still armed by later write, accepted now
        step(1, 0, 8'h55, 1, 0, 0, 0);
        step(0, 1, 8'h00, 1, 0, 0, 1);
        // R9: re-issue without re-arming ignored
        step(1, 0, 8'h55, 1, 0, 0, 0);
        // R2: armed mass erase with debug disabled ignored, then accepted
        step(1, 2, 8'h01, 0, 0, 0, 0);
        step(1, 0, 8'hAA, 0, 0, 0, 0);
        step(1, 0, 8'hAA, 1, 0, 0, 0);
        step(0, 2, 8'h00, 1, 0, 0, 1);
        // R3: other key values
        step(1, 1, 8'h10, 1, 0, 0, 0);
        step(1, 0, 8'h56, 1, 0, 0, 0);
        step(1, 0, 8'h00, 1, 0, 0, 0);
        // R6: blocked by irq_en, then set, then cleared with priority
        step(1, 3, 8'h01, 1, 1, 0, 0);
        step(1, 3, 8'h01, 1, 0, 0, 0);
        step(1, 3, 8'h01, 1, 0, 1, 0);
        // R7: zero ignored, one sets, zero cannot clear
        step(1, 4, 8'h00, 1, 0, 0, 0);
        step(1, 4, 8'h01, 1, 0, 0, 0);
        step(1, 4, 8'hFE, 1, 0, 0, 0);
        // R10: unmapped reads
        step(0, 5, 8'h00, 1, 0, 0, 0);
        step(0, 7, 8'h00, 1, 0, 0, 0);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] d;
            int r;
            r = $urandom_range(0, 3);
            d = (r == 0) ? 8'h55 : (r == 1) ? 8'hAA : 8'($urandom);
            step($urandom_range(0, 1), 3'($urandom_range(0, 7)), d,
                 $urandom_range(0, 3) != 0, $urandom_range(0, 3) == 0,
                 $urandom_range(0, 9) == 0, m_busy && $urandom_range(0, 3) == 0);
        end
        @(negedge clk);
        check_outputs();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule